// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block sits on a microcontroller's byte-wide special-function-register bus and guards the erase path of an on-chip flash array. Software must first arm an erase by writing a prerequisite register. It then writes an unlock pattern to a command register. A page erase needs a valid page number written to the page register. A mass erase needs a write to the mass-enable register and an asserted debug-enable input. Any other command byte, or a command that has not been armed, is discarded.

An accepted command is handed to the flash array over a request/acknowledge handshake. The handshake carries the erase kind and a 7-bit page number, and the block stays busy until the array returns a done pulse. Each arming is used up by one issued erase, so every new erase needs a fresh prerequisite write. Busy can be read back through a status register.

Top module: `ferase_seq`

## Requirements
- R1: Reset clears both arming flags, the busy flag and the page register, and leaves `fl_req` low. After reset the page register and the status register both read 0x00.
- R2: A write of 0x55 to address 0x94 while the page erase is armed and the block is idle issues a page erase. One cycle after that write edge, `fl_req`=1, `fl_mass`=0, `fl_page` equals the stored page number and `busy`=1.
- R3: A 0x55 command with no earlier page-register write (address 0xB7) issues nothing.
- R4: Issuing a page erase disarms it. A second 0x55 without a new write to 0xB7 issues nothing.
- R5: A write of any value to address 0xB2, followed by 0xAA to 0x94 while `dbg_en`=1 and idle, issues a mass erase. One cycle after the command edge, `fl_req`=1, `fl_mass`=1 and `busy`=1.
- R6: A 0xAA command while `dbg_en`=0 issues nothing and keeps the mass arming.
- R7: A command byte other than 0x55 or 0xAA issues nothing and changes no arming.
- R8: A page-register write with bit 7 set leaves the stored page unchanged and leaves page erase unarmed.
- R9: A command written while `busy`=1 is ignored. Arming writes made during busy still take effect.
- R10: `fl_req` stays high, with `fl_mass` and `fl_page` stable, until `fl_ack` is sampled high. It drops one cycle after that. `busy` stays high until `fl_done` is sampled, and clears one cycle after it.
- R11: Reads are combinational while `sfr_re`=1. Address 0x94 reads 0x00. Address 0xB7 reads {0, page}. Address 0xB5 reads {7'b0, busy}. Every other address, including 0xB2, reads 0x00.
- R12: Any issued erase, page or mass, clears both the page arming and the mass arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_we | input | 1 | Write strobe |
| sfr_re | input | 1 | Read strobe |
| sfr_rdata | output | 8 | Read data |
| dbg_en | input | 1 | Debug port enabled, gates mass erase |
| fl_req | output | 1 | Erase request to flash |
| fl_mass | output | 1 | Erase kind: 1 mass, 0 page |
| fl_page | output | 7 | Page number for page erase |
| fl_ack | input | 1 | Flash accepted the request |
| fl_done | input | 1 | Flash finished the erase |
| busy | output | 1 | Erase in flight |

## Verification
A command write lands on one rising edge, and the request, erase kind, page and busy are due in the cycle that follows. Read data is due in the same cycle the read strobe is held. A drop of the request is due one cycle after the edge that samples the acknowledge, and a drop of busy one cycle after the edge that samples done. The driver changes inputs just after a rising edge and queues each expected value once that edge has passed. The monitor compares the queued values on the next falling edge, so every result is sampled in the cycle it is due.

// File: rtl/ferase_pkg.sv
package ferase_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int PAGE_W = 7;

    localparam logic [ADDR_W-1:0] A_CMD  = 8'h94;
    localparam logic [ADDR_W-1:0] A_PAGE = 8'hB7;
    localparam logic [ADDR_W-1:0] A_MEEN = 8'hB2;
    localparam logic [ADDR_W-1:0] A_STAT = 8'hB5;

    localparam logic [DATA_W-1:0] PAT_PAGE = 8'h55;
    localparam logic [DATA_W-1:0] PAT_MASS = 8'hAA;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_REQ  = 2'd1,
        HS_WAIT = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic              mass;
        logic [PAGE_W-1:0] page;
    } erase_cmd_t;

    function automatic logic page_in_range(input logic [DATA_W-1:0] d);
        return d[DATA_W-1:PAGE_W] == '0;
    endfunction
endpackage

// File: rtl/ferase_regs.sv
module ferase_regs
    import ferase_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    input  logic [PAGE_W-1:0] page_q,
    input  logic              busy,
    output logic              wr_cmd,
    output logic              wr_page,
    output logic              wr_meen,
    output logic [DATA_W-1:0] rdata
);
    assign wr_cmd  = we && (addr == A_CMD);
    assign wr_page = we && (addr == A_PAGE);
    assign wr_meen = we && (addr == A_MEEN);

    always_comb begin
        rdata = '0;
        if (re) begin
            unique case (addr)
                A_PAGE:  rdata = {{(DATA_W-PAGE_W){1'b0}}, page_q};
                A_STAT:  rdata = {{(DATA_W-1){1'b0}}, busy};
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ferase_arm.sv
module ferase_arm
    import ferase_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cmd,
    input  logic              wr_page,
    input  logic              wr_meen,
    input  logic [DATA_W-1:0] wdata,
    input  logic              dbg_en,
    input  logic              busy,
    output logic              issue,
    output erase_cmd_t        issue_cmd,
    output logic [PAGE_W-1:0] page_q
);
    logic page_arm;
    logic mass_arm;
    logic pg_go;
    logic ms_go;

    assign pg_go = wr_cmd && !busy && (wdata == PAT_PAGE) && page_arm;
    assign ms_go = wr_cmd && !busy && (wdata == PAT_MASS) && mass_arm && dbg_en;
    assign issue = pg_go || ms_go;

    always_comb begin
        issue_cmd.mass = ms_go;
        issue_cmd.page = page_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_arm <= 1'b0;
            mass_arm <= 1'b0;
            page_q   <= '0;
        end else begin
            if (wr_page) begin
                if (page_in_range(wdata)) begin
                    page_q   <= wdata[PAGE_W-1:0];
                    page_arm <= 1'b1;
                end else begin
                    page_arm <= 1'b0;
                end
            end
            if (wr_meen) begin
                mass_arm <= 1'b1;
            end
            if (issue) begin
                page_arm <= 1'b0;
                mass_arm <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ferase_hs.sv
module ferase_hs
    import ferase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       issue,
    input  erase_cmd_t cmd,
    input  logic       ack,
    input  logic       done,
    output logic       req,
    output erase_cmd_t cmd_q,
    output logic       busy
);
    hs_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_IDLE;
            cmd_q <= '0;
        end else begin
            unique case (state)
                HS_IDLE: if (issue) begin
                    state <= HS_REQ;
                    cmd_q <= cmd;
                end
                HS_REQ:  if (ack)  state <= HS_WAIT;
                HS_WAIT: if (done) state <= HS_IDLE;
                default: state <= HS_IDLE;
            endcase
        end
    end

    assign req  = (state == HS_REQ);
    assign busy = (state != HS_IDLE);
endmodule

// File: rtl/ferase_seq.sv
module ferase_seq
    import ferase_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    input  logic              sfr_we,
    input  logic              sfr_re,
    output logic [DATA_W-1:0] sfr_rdata,
    input  logic              dbg_en,
    output logic              fl_req,
    output logic              fl_mass,
    output logic [PAGE_W-1:0] fl_page,
    input  logic              fl_ack,
    input  logic              fl_done,
    output logic              busy
);
    logic              wr_cmd, wr_page, wr_meen;
    logic              issue;
    erase_cmd_t        issue_cmd;
    erase_cmd_t        cmd_q;
    logic [PAGE_W-1:0] page_q;

    ferase_regs u_regs (
        .addr    (sfr_addr),
        .we      (sfr_we),
        .re      (sfr_re),
        .page_q  (page_q),
        .busy    (busy),
        .wr_cmd  (wr_cmd),
        .wr_page (wr_page),
        .wr_meen (wr_meen),
        .rdata   (sfr_rdata)
    );

    ferase_arm u_arm (
        .clk       (clk),
        .rst       (rst),
        .wr_cmd    (wr_cmd),
        .wr_page   (wr_page),
        .wr_meen   (wr_meen),
        .wdata     (sfr_wdata),
        .dbg_en    (dbg_en),
        .busy      (busy),
        .issue     (issue),
        .issue_cmd (issue_cmd),
        .page_q    (page_q)
    );

    ferase_hs u_hs (
        .clk   (clk),
        .rst   (rst),
        .issue (issue),
        .cmd   (issue_cmd),
        .ack   (fl_ack),
        .done  (fl_done),
        .req   (fl_req),
        .cmd_q (cmd_q),
        .busy  (busy)
    );

    assign fl_mass = cmd_q.mass;
    assign fl_page = cmd_q.page;
endmodule

// File: rtl/ferase_seq_chk.sv
module ferase_seq_chk
    import ferase_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic              sfr_we,
    input logic              sfr_re,
    input logic [DATA_W-1:0] sfr_rdata,
    input logic              dbg_en,
    input logic              fl_req,
    input logic              fl_mass,
    input logic [PAGE_W-1:0] fl_page,
    input logic              fl_ack,
    input logic              fl_done,
    input logic              busy
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!fl_req && !busy));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_mass) && $stable(fl_page)));

    // R10
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(fl_done));

    // R9
    no_issue_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_req) |-> !$past(busy));

    // R2
    issue_from_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_req) |-> $past(sfr_we && sfr_addr == A_CMD));

    // R5
    mass_needs_dbg_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(fl_req) && fl_mass) |-> $past(dbg_en));

    // R11
    cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sfr_re && sfr_addr == A_CMD) |-> (sfr_rdata == '0));

    // R10
    req_implies_busy_chk: assert property (@(posedge clk) disable iff (rst)
        fl_req |-> busy);
endmodule

bind ferase_seq ferase_seq_chk u_chk (.*);

// File: tb/ferase_seq_tb.sv
`timescale 1ns/1ps
module ferase_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sfr_addr = '0;
    logic [7:0] sfr_wdata = '0;
    logic       sfr_we = 1'b0;
    logic       sfr_re = 1'b0;
    logic [7:0] sfr_rdata;
    logic       dbg_en = 1'b0;
    logic       fl_req;
    logic       fl_mass;
    logic [6:0] fl_page;
    logic       fl_ack = 1'b0;
    logic       fl_done = 1'b0;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    string       q_rq[$];
    logic [17:0] q_exp[$];
    logic [17:0] q_msk[$];

    always #2 clk = ~clk;

    ferase_seq u_dut (
        .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_we(sfr_we), .sfr_re(sfr_re), .sfr_rdata(sfr_rdata), .dbg_en(dbg_en),
        .fl_req(fl_req), .fl_mass(fl_mass), .fl_page(fl_page),
        .fl_ack(fl_ack), .fl_done(fl_done), .busy(busy)
    );

    // monitor: compare queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q_rq.size() > 0) begin
                string       rq;
                logic [17:0] e, m, obs;
                rq = q_rq.pop_front();
                e  = q_exp.pop_front();
                m  = q_msk.pop_front();
                obs = {fl_req, fl_mass, fl_page, busy, sfr_rdata};
                checks++;
                if ((obs & m) !== (e & m)) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h mask=%h", rq, obs & m, e & m, m);
                end
            end
        end
    end

    task automatic push(input string rq, input logic [17:0] e, input logic [17:0] m);
        q_rq.push_back(rq);
        q_exp.push_back(e);
        q_msk.push_back(m);
    endtask

    // expect flash side; page checked only when want_pg
    task automatic exp_fl(input string rq, input logic req, input logic mass,
                          input logic [6:0] pg, input logic bsy, input bit want_km);
        logic [17:0] m;
        m = want_km ? 18'h3FF00 : 18'h20100;
        push(rq, {req, mass, pg, bsy, 8'h00}, m);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        @(posedge clk); #1;
        sfr_we = 1'b0;
    endtask

    task automatic rd(input string rq, input logic [7:0] a, input logic [7:0] e);
        @(posedge clk); #1;
        sfr_addr = a; sfr_re = 1'b1;
        push(rq, {10'b0, e}, 18'h000FF);
        @(posedge clk); #1;
        sfr_re = 1'b0;
    endtask

    task automatic pulse_ack;
        @(posedge clk); #1; fl_ack = 1'b1;
        @(posedge clk); #1; fl_ack = 1'b0;
    endtask

    task automatic pulse_done;
        @(posedge clk); #1; fl_done = 1'b1;
        @(posedge clk); #1; fl_done = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        exp_fl("R1 reset outputs", 0, 0, 0, 0, 0);
        rd("R1 page reads zero", 8'hB7, 8'h00);
        rd("R1 status reads zero", 8'hB5, 8'h00);

        wr(8'h94, 8'h55);
        exp_fl("R3 unarmed page erase", 0, 0, 0, 0, 0);

        wr(8'hB7, 8'h2A);
        wr(8'h94, 8'h55);
        exp_fl("R2 page erase issued", 1, 0, 7'h2A, 1, 1);
        idle(3);
        exp_fl("R10 request held", 1, 0, 7'h2A, 1, 1);
        // R9: arm both while busy, then try commands
        wr(8'hB7, 8'h10);
        wr(8'hB2, 8'h01);
        dbg_en = 1'b1;
        wr(8'h94, 8'hAA);
        exp_fl("R9 mass ignored while busy", 1, 0, 7'h2A, 1, 1);
        wr(8'h94, 8'h55);
        exp_fl("R9 page ignored while busy", 1, 0, 7'h2A, 1, 1);
        rd("R11 status busy", 8'hB5, 8'h01);
        rd("R11 command reads zero", 8'h94, 8'h00);
        pulse_ack();
        exp_fl("R10 request drops after ack", 0, 0, 0, 1, 0);
        idle(2);
        exp_fl("R10 busy held until done", 0, 0, 0, 1, 0);
        pulse_done();
        exp_fl("R10 busy clears after done", 0, 0, 0, 0, 0);

        dbg_en = 1'b0;
        wr(8'h94, 8'hAA);
        exp_fl("R6 mass blocked without debug", 0, 0, 0, 0, 0);
        dbg_en = 1'b1;
        wr(8'h94, 8'hAA);
        exp_fl("R5 mass erase issued (R6 arm kept)", 1, 1, 7'h10, 1, 0);
        push("R5 mass kind", {1'b1, 1'b1, 16'h0}, 18'h30000);
        pulse_ack();
        pulse_done();

        wr(8'h94, 8'h55);
        exp_fl("R12 page arm cleared by mass", 0, 0, 0, 0, 0);
        wr(8'h94, 8'hAA);
        exp_fl("R12 mass arm cleared by mass", 0, 0, 0, 0, 0);

        wr(8'hB7, 8'h05);
        wr(8'hB2, 8'h00);
        wr(8'h94, 8'h55);
        exp_fl("R2 page erase page 05", 1, 0, 7'h05, 1, 1);
        pulse_ack();
        pulse_done();
        wr(8'h94, 8'h55);
        exp_fl("R4 page arm consumed", 0, 0, 0, 0, 0);
        wr(8'h94, 8'hAA);
        exp_fl("R12 mass arm cleared by page", 0, 0, 0, 0, 0);

        wr(8'hB7, 8'h33);
        wr(8'h94, 8'h12);
        exp_fl("R7 other pattern ignored", 0, 0, 0, 0, 0);
        wr(8'h94, 8'h55);
        exp_fl("R7 arming kept after bad pattern", 1, 0, 7'h33, 1, 1);
        pulse_ack();
        pulse_done();

        wr(8'hB7, 8'h87);
        rd("R8 page unchanged by out-of-range", 8'hB7, 8'h33);
        wr(8'h94, 8'h55);
        exp_fl("R8 out-of-range does not arm", 0, 0, 0, 0, 0);

        rd("R11 mass-enable reads zero", 8'hB2, 8'h00);
        rd("R11 unused address reads zero", 8'h00, 8'h00);

        wr(8'hB7, 8'h44);
        wr(8'hB2, 8'h01);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        rd("R1 page cleared by reset", 8'hB7, 8'h00);
        wr(8'h94, 8'h55);
        exp_fl("R1 page arm cleared by reset", 0, 0, 0, 0, 0);
        wr(8'h94, 8'hAA);
        exp_fl("R1 mass arm cleared by reset", 0, 0, 0, 0, 0);

        idle(2);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule